// File: doc/BRIEF.md
# Oversampling Serial Receiver with Programmable Bit-Rate Divider

This block receives asynchronous serial characters. A free-running divider turns the system clock into a sampling tick that runs at sixteen times the bit rate. The divisor is 16 bits wide and is loaded one byte at a time through two write strobes that share a single data byte. With divisor D, the bit rate is the clock frequency divided by 16·D. A divisor of zero stops the tick, and the receiver then stays idle.

The serial line passes through a two-flop synchronizer before the receiver uses it. While hunting, the receiver counts consecutive ticks with the line low. The eighth such tick marks the middle of a start bit and locks the bit timing. Each data, parity and stop bit is then sampled exactly sixteen ticks after the previous sample, which places each sample near the bit centre.

After the final stop sample, the receiver presents the character for one clock with its parity and framing status, and then hunts again. Word length, parity and stop-bit count come from a 5-bit format input, which must be held steady while a character is in flight.

Top module: `uart_os_rx`

## Requirements
- R1: The divisor register resets to 0. A pulse on `div_lo_we_i` loads `div_wdata_i` into divisor bits 7:0, and a pulse on `div_hi_we_i` loads it into bits 15:8.
- R2: With divisor D > 0, the sampling tick fires once every D clocks, so one bit lasts 16·D clocks. D = 1 ticks on every clock and D = 2 ticks on every second clock.
- R3: With divisor 0 there is no tick, and a complete frame on `rxd_i` produces no `valid_o` pulse.
- R4: The line is sampled through two flops. A start bit locks after 8 consecutive low ticks. The n-th bit sample falls 16·n ticks after the lock tick, and `valid_o` rises one clock after the tick that takes the last sample.
- R5: If the line goes high before 8 consecutive low ticks, the low count is cleared. A later start bit then needs a fresh run of 8 low ticks.
- R6: Data bits arrive least significant bit first. `fmt_i[1:0]` selects 5, 6, 7 or 8 data bits (encoded 0 to 3). `data_o` carries the bits right-aligned with the unused upper bits zero.
- R7: `fmt_i[3]` = 1 adds one parity bit after the data bits. `fmt_i[4]` = 1 selects even parity and 0 selects odd. A parity bit that does not match sets `par_err_o` for that character; the flag is 0 when parity is off.
- R8: `fmt_i[2]` = 1 selects two stop bits, and 0 selects one. A low level at any stop-bit sample sets `frm_err_o` for that character.
- R9: `valid_o` is a single-clock pulse. `data_o`, `par_err_o` and `frm_err_o` change only together with `valid_o` and hold their values between characters. All outputs are 0 after reset.
- R10: After the last stop sample, the receiver hunts again, so characters separated by only one idle bit time are each received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_lo_we_i | input | 1 | Write strobe for divisor bits 7:0 |
| div_hi_we_i | input | 1 | Write strobe for divisor bits 15:8 |
| div_wdata_i | input | 8 | Divisor byte to write |
| fmt_i | input | 5 | Character format: [1:0] word length − 5, [2] two stop bits, [3] parity enable, [4] even parity |
| rxd_i | input | 1 | Serial input line, idle high |
| data_o | output | 8 | Last received character, right-aligned |
| valid_o | output | 1 | One-clock pulse when a character completes |
| par_err_o | output | 1 | Parity mismatch on the last character |
| frm_err_o | output | 1 | Low stop-bit sample on the last character |

## Verification
A character's result is due at a cycle that can be computed. If the line falls just after clock k, the first low tick lands between clock k+3 and clock k+2+D. For a frame of n samples, `valid_o` then appears exactly (7+16·n)·D clocks after that first tick. The bench records the clock count of every pulse from the negative edge and compares it against this window, widened by one clock at each end. A start run that has been cut short and not cleared would shift the pulse by several ticks and fall outside the window. A missing or extra pulse is caught by counting pulses per frame, checked one full idle bit after the last stop bit, well after the result is due.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_BITS = 1'b1
    } rx_state_e;

    // Format word; the first field sits in the most significant bit.
    typedef struct packed {
        logic       par_even;
        logic       par_en;
        logic       stop2;
        logic [1:0] wlen;
    } rx_fmt_t;

endpackage

// File: rtl/uart_os_sync.sv
module uart_os_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end else begin : g_single
            always_comb sh_d = d_i;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RESET_VAL}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/uart_os_baudgen.sv
module uart_os_baudgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    always_comb begin
        at_end = (div_i != '0) && (cnt_q >= div_i - DIV_W'(1));
        if (div_i == '0)  cnt_d = '0;
        else if (at_end)  cnt_d = '0;
        else              cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = at_end;
endmodule

// File: rtl/uart_os_rxfsm.sv
module uart_os_rxfsm
    import uart_os_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OS        = 16,
    parameter int START_LOW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              rx_i,
    input  rx_fmt_t           fmt_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              par_err_o,
    output logic              frm_err_o
);
    localparam int MIN_W = DATA_W - 3;
    localparam int OS_W  = $clog2(OS);
    localparam int LOW_W = $clog2(START_LOW > 1 ? START_LOW : 2);
    localparam int IDX_W = $clog2(DATA_W + 4);

    typedef struct packed {
        rx_state_e         st;
        logic [LOW_W-1:0]  low;
        logic [OS_W-1:0]   os;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par_acc;
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              par_err;
        logic              frm_err;
    } rx_reg_t;

    rx_reg_t          r_d, r_q;
    logic [IDX_W-1:0] n_data, n_par, n_last;

    always_comb begin
        n_data = IDX_W'(MIN_W) + IDX_W'(fmt_i.wlen);
        n_par  = n_data + IDX_W'(fmt_i.par_en);
        n_last = n_par + IDX_W'(fmt_i.stop2);

        r_d       = r_q;
        r_d.valid = 1'b0;

        if (tick_i) begin
            case (r_q.st)
                ST_HUNT: begin
                    if (rx_i) begin
                        r_d.low = '0;
                    end else if (r_q.low == LOW_W'(START_LOW - 1)) begin
                        r_d.st      = ST_BITS;
                        r_d.low     = '0;
                        r_d.os      = '0;
                        r_d.idx     = '0;
                        r_d.sh      = '0;
                        r_d.par_acc = 1'b0;
                        r_d.perr    = 1'b0;
                        r_d.ferr    = 1'b0;
                    end else begin
                        r_d.low = r_q.low + LOW_W'(1);
                    end
                end
                default: begin
                    r_d.os = r_q.os + OS_W'(1);
                    if (r_q.os == OS_W'(OS - 1)) begin
                        r_d.os  = '0;
                        r_d.idx = r_q.idx + IDX_W'(1);
                        if (r_q.idx < n_data) begin
                            r_d.sh      = {rx_i, r_q.sh[DATA_W-1:1]};
                            r_d.par_acc = r_q.par_acc ^ rx_i;
                        end else if (fmt_i.par_en && (r_q.idx == n_data)) begin
                            r_d.perr = ((r_q.par_acc ^ rx_i) == fmt_i.par_even);
                        end else if (!rx_i) begin
                            r_d.ferr = 1'b1;
                        end
                        if (r_q.idx == n_last) begin
                            r_d.st      = ST_HUNT;
                            r_d.valid   = 1'b1;
                            r_d.data    = r_d.sh >> (IDX_W'(DATA_W) - n_data);
                            r_d.par_err = r_d.perr;
                            r_d.frm_err = r_d.ferr;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign data_o    = r_q.data;
    assign valid_o   = r_q.valid;
    assign par_err_o = r_q.par_err;
    assign frm_err_o = r_q.frm_err;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int DATA_W    = 8,
    parameter int OS        = 16,
    parameter int START_LOW = 8,
    parameter int SYNC_ST   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              div_lo_we_i,
    input  logic              div_hi_we_i,
    input  logic [BYTE_W-1:0] div_wdata_i,
    input  logic [4:0]        fmt_i,
    input  logic              rxd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              par_err_o,
    output logic              frm_err_o
);
    localparam int DIV_W = 2 * BYTE_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [DIV_W-1:0] div_val;
    logic             baud_tick;
    logic             rx_s;

    always_comb begin
        cfg_d = cfg_q;
        if (div_lo_we_i) cfg_d.div[BYTE_W-1:0]      = div_wdata_i;
        if (div_hi_we_i) cfg_d.div[DIV_W-1:BYTE_W]  = div_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign div_val = cfg_q.div;

    uart_os_baudgen #(.DIV_W(DIV_W)) u_baud (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_i  (div_val),
        .tick_o (baud_tick)
    );

    uart_os_sync #(.STAGES(SYNC_ST), .RESET_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rxd_i),
        .q_o    (rx_s)
    );

    uart_os_rxfsm #(.DATA_W(DATA_W), .OS(OS), .START_LOW(START_LOW)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (baud_tick),
        .rx_i      (rx_s),
        .fmt_i     (rx_fmt_t'(fmt_i)),
        .data_o    (data_o),
        .valid_o   (valid_o),
        .par_err_o (par_err_o),
        .frm_err_o (frm_err_o)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        div_lo_we_i,
    input logic        div_hi_we_i,
    input logic [7:0]  div_wdata_i,
    input logic [15:0] div_val,
    input logic        tick,
    input logic [7:0]  data_o,
    input logic        valid_o,
    input logic        par_err_o,
    input logic        frm_err_o
);
    AST_DIV_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_lo_we_i |=> div_val[7:0] == $past(div_wdata_i)); // R1

    AST_DIV_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_hi_we_i |=> div_val[15:8] == $past(div_wdata_i)); // R1

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && div_val > 16'd1 && !div_lo_we_i && !div_hi_we_i) |=> !tick); // R2

    AST_ZERO_DIV_NO_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_val == 16'd0) |=> !valid_o); // R3

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(data_o) && $stable(par_err_o) && $stable(frm_err_o))); // R9
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_lo_we_i (div_lo_we_i),
    .div_hi_we_i (div_hi_we_i),
    .div_wdata_i (div_wdata_i),
    .div_val     (div_val),
    .tick        (baud_tick),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .par_err_o   (par_err_o),
    .frm_err_o   (frm_err_o)
);

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_lo_we = 1'b0;
    logic       div_hi_we = 1'b0;
    logic [7:0] div_wdata = 8'h00;
    logic [4:0] fmt = 5'b00011;
    logic       rxd = 1'b1;
    logic [7:0] data_o;
    logic       valid_o, par_err_o, frm_err_o;

    int n_chk = 0;
    int n_fail = 0;
    int cur_div = 1;
    int cyc = 0;
    int pulses = 0;
    int got_cyc = 0;
    logic [7:0] got_data = 8'h00;
    logic got_pe = 1'b0;
    logic got_fe = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_os_rx u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .div_lo_we_i (div_lo_we),
        .div_hi_we_i (div_hi_we),
        .div_wdata_i (div_wdata),
        .fmt_i       (fmt),
        .rxd_i       (rxd),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .par_err_o   (par_err_o),
        .frm_err_o   (frm_err_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (valid_o) begin
            pulses   = pulses + 1;
            got_cyc  = cyc;
            got_data = data_o;
            got_pe   = par_err_o;
            got_fe   = frm_err_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_div(input int d);
        @(negedge clk);
        div_lo_we = 1'b1; div_wdata = 8'(d);
        @(negedge clk);
        div_lo_we = 1'b0; div_hi_we = 1'b1; div_wdata = 8'(d >> 8);
        @(negedge clk);
        div_hi_we = 1'b0;
        cur_div = d;
    endtask

    task automatic bit_wait();
        repeat (16 * cur_div) @(negedge clk);
    endtask

    // Sends one frame; expect_char = 0 means no character may appear.
    task automatic send_frame(input logic [7:0] data, input logic [4:0] f,
                              input bit bad_par, input bit bad_stop,
                              input bit expect_char, input string ttag);
        int nb, np, ns, n, k, p0, lo, hi;
        logic [7:0] d;
        logic p;
        nb = 5 + int'(f[1:0]);
        np = int'(f[3]);
        ns = f[2] ? 2 : 1;
        n  = nb + np + ns;
        d  = data & 8'((1 << nb) - 1);
        p  = f[4] ? ^d : ~^d;
        if (bad_par) p = ~p;
        fmt = f;
        p0  = pulses;
        @(negedge clk);
        rxd = 1'b0; k = cyc;
        bit_wait();
        for (int i = 0; i < nb; i++) begin rxd = d[i]; bit_wait(); end
        if (np != 0) begin rxd = p; bit_wait(); end
        for (int s = 0; s < ns; s++) begin rxd = !(bad_stop && s == 0); bit_wait(); end
        rxd = 1'b1;
        bit_wait();
        if (!expect_char) begin
            chk(pulses == p0, "R3", "pulses with zero divisor", pulses - p0, 0);
        end else begin
            chk(pulses - p0 == 1, "R10", "characters per frame", pulses - p0, 1);
            chk(got_data == d, "R6", "data", int'(got_data), int'(d));
            chk(got_pe == (np != 0 && bad_par), "R7", "parity error",
                int'(got_pe), int'(np != 0 && bad_par));
            chk(got_fe == bad_stop, "R8", "framing error", int'(got_fe), int'(bad_stop));
            lo = k + 3 + (7 + 16 * n) * cur_div;
            hi = k + 2 + cur_div + (7 + 16 * n) * cur_div;
            chk(got_cyc >= lo - 1 && got_cyc <= hi + 1, ttag, "valid cycle", got_cyc, lo);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: outputs idle after reset
        chk(valid_o == 1'b0, "R9", "reset valid", int'(valid_o), 0);
        chk(data_o == 8'h00, "R9", "reset data", int'(data_o), 0);
        chk(par_err_o == 1'b0 && frm_err_o == 1'b0, "R9", "reset flags",
            int'({par_err_o, frm_err_o}), 0);

        // R3: divisor still 0 after reset, so no character
        cur_div = 1;
        send_frame(8'h3C, 5'b00011, 1'b0, 1'b0, 1'b0, "R3");

        // R6 / R2: every byte value, 8 data bits, no parity, one stop, D = 1
        write_div(1);
        for (int v = 0; v < 256; v++)
            send_frame(8'(v), 5'b00011, 1'b0, 1'b0, 1'b1, "R2");

        // R4 / R7 / R8: all formats at D = 1 and D = 2
        for (int dv = 1; dv <= 2; dv++) begin
            write_div(dv);
            for (int f = 0; f < 32; f++)
                send_frame(8'h5A ^ 8'(f * 37), 5'(f), 1'b0, 1'b0, 1'b1, "R4");
        end

        // R7: parity mismatch for each parity-enabled format
        for (int f = 0; f < 32; f++)
            if (f[3]) send_frame(8'(f * 11 + 3), 5'(f), 1'b1, 1'b0, 1'b1, "R4");

        // R8: low first stop bit with two stop bits selected
        for (int f = 0; f < 32; f++)
            if (f[2]) send_frame(8'(f * 23 + 1), 5'(f), 1'b0, 1'b1, 1'b1, "R4");

        // R5: six low ticks, line high again, then a real frame
        begin
            int p0;
            p0 = pulses;
            @(negedge clk);
            rxd = 1'b0;
            repeat (6 * cur_div) @(negedge clk);
            rxd = 1'b1;
            repeat (2 * cur_div) @(negedge clk);
            chk(pulses == p0, "R5", "short low run pulses", pulses - p0, 0);
            send_frame(8'hA7, 5'b00011, 1'b0, 1'b0, 1'b1, "R5");
        end

        // R1 / R2: divisor set only through the high byte (256)
        write_div(16'h0100);
        send_frame(8'h15, 5'b00000, 1'b0, 1'b0, 1'b1, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule